// File: doc/BRIEF.md
# Round-Robin Three-Bank Stage Buffer

This block sits between two stages of a pipelined row-column 8x8 transform. It replaces paired flip-flop arrays with three blocks of dual-port RAM. The upstream stage fills one block of eight 20-bit coefficients while the downstream stage reads a block that was finished earlier. Because there are three blocks, filling, processing and draining can all overlap on different blocks.

Each side raises a request and gives a local element address from 0 to 7. The buffer answers with an enable in the same cycle. A transfer happens only on a clock edge where that enable is high. The buffer turns the local address into a physical RAM address by adding the base offset of the bank that side currently owns.

A bank passes from the writer to the reader once its element 7 has been written. It returns to the free pool once the reader has fetched its element 7. The write-side and read-side bank pointers each step through 0, 1, 2 in turn, so finished blocks are read in the order they were written. There is a single read port, so a consumer that needs two operands spends two cycles fetching them.

Top module: `stbuf_rr`

## Requirements
- R1: After reset, all three banks are free. A write request is granted, `rd_en` stays low while no bank is full, and `rd_valid` is low.
- R2: `wr_en` is high exactly when `wr_req` is high and at least one bank is free. A write is stored only on an edge where `wr_en` is high.
- R3: When three banks are full and none has been drained, `wr_en` stays low whatever `wr_req` does, so no block is overwritten.
- R4: The reader gets no grant on a bank until local address 7 of that bank has been written. `rd_en` becomes available in the cycle after that write edge.
- R5: `rd_en` is high exactly when `rd_req` is high and at least one bank is full.
- R6: On the cycle after a read edge, `rd_valid` is high and `rd_data` holds the 20-bit value last written at that local address of the oldest full bank. `rd_valid` is low in every other cycle. Only one element is read per cycle.
- R7: A granted read of local address 7 releases that bank. Banks are filled and drained in the order 0, 1, 2, 0, and so on, so blocks leave in write order with no loss and no duplication.
- R8: When a block is completed and another block is released on the same edge, both take effect and the number of full banks is unchanged.
- R9: All 20 data bits are preserved, including the patterns 0xFFFFF and 0x80000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Producer requests a write |
| wr_addr | input | 3 | Producer local element address |
| wr_data | input | 20 | Coefficient to store |
| wr_en | output | 1 | Write grant; the write happens on this edge |
| rd_req | input | 1 | Consumer requests a read |
| rd_addr | input | 3 | Consumer local element address |
| rd_en | output | 1 | Read grant; the fetch happens on this edge |
| rd_data | output | 20 | Fetched coefficient, one cycle after `rd_en` |
| rd_valid | output | 1 | `rd_data` is valid this cycle |

## Verification
A block can be completed on the write side in the same cycle that another block is released on the read side. The bench provokes this by starting a writer and a reader together with no stalls, so their eighth elements are granted on the same edge. It then judges the result at the ports. It writes exactly one more block, which must be granted in full. It then checks that a further write request is refused, which shows the buffer holds three full banks and not two or four. Random stalls on both sides afterwards make the producer stall and the consumer starve in changing combinations, and a scoreboard checks the order of every coefficient.

// File: rtl/stbuf_pkg.sv
// Shared helpers for the round-robin stage buffer.
// Assumes bank counts are small (ring indices fit in 32 bits).
package stbuf_pkg;

    // Advance a ring index modulo n.
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        return (idx == n - 1) ? 0 : idx + 1;
    endfunction

    // Base element offset of a given bank.
    function automatic int unsigned bank_base(input int unsigned idx, input int unsigned elems);
        return idx * elems;
    endfunction

endpackage

// File: rtl/stbuf_ring_ptr.sv
// Bank ownership pointer for one side of the buffer.
// Holds the owned bank index and its base offset, and advances both
// modulo NUM_BANKS on 'advance'. It produces the physical address as
// base plus local address. Assumes the local address is below ELEMS.
module stbuf_ring_ptr #(
    parameter int NUM_BANKS = 3,
    parameter int ELEMS     = 8,
    localparam int LA_W  = $clog2(ELEMS),
    localparam int PA_W  = $clog2(NUM_BANKS * ELEMS),
    localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    input  logic [LA_W-1:0] local_addr,
    output logic [PA_W-1:0] phys_addr
);
    import stbuf_pkg::*;

    logic [IDX_W-1:0] idx_q;
    logic [PA_W-1:0]  base_q;

    // Step the owned bank and its offset to the next bank in the ring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            base_q <= '0;
        end else if (advance) begin
            idx_q  <= IDX_W'(ring_next(32'(idx_q), NUM_BANKS));
            base_q <= PA_W'(bank_base(ring_next(32'(idx_q), NUM_BANKS), ELEMS));
        end
    end

    // Map the local address into the owned bank.
    always_comb phys_addr = base_q + PA_W'(local_addr);

endmodule

// File: rtl/stbuf_occupancy.sv
// Counts full banks and grants both sides.
// A write is granted while a free bank exists. A read is granted while
// a full bank exists. A granted write to the last element completes a
// bank and a granted read of the last element releases one.
// Assumes both sides see the same count and only one bank changes per side per cycle.
module stbuf_occupancy #(
    parameter int NUM_BANKS = 3,
    localparam int CNT_W = $clog2(NUM_BANKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic wr_last,
    input  logic rd_req,
    input  logic rd_last,
    output logic wr_en,
    output logic rd_en,
    output logic wr_done,
    output logic rd_done
);
    logic [CNT_W-1:0] full_q;

    // Grant decisions from the current fill level.
    always_comb begin
        wr_en   = wr_req && (full_q != CNT_W'(NUM_BANKS));
        rd_en   = rd_req && (full_q != '0);
        wr_done = wr_en && wr_last;
        rd_done = rd_en && rd_last;
    end

    // Track full banks; a completion and a release on the same edge cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full_q <= '0;
        else if (wr_done && !rd_done)
            full_q <= full_q + 1'b1;
        else if (rd_done && !wr_done)
            full_q <= full_q - 1'b1;
    end

endmodule

// File: rtl/stbuf_dpram.sv
// Simple dual-port RAM: one write port and one synchronous read port.
// The read data register updates only on a read, with one cycle of
// latency. REG_RESET picks whether that register is reset.
module stbuf_dpram #(
    parameter int    WIDTH     = 20,
    parameter int    WORDS     = 24,
    parameter bit    REG_RESET = 1'b1,
    localparam int   AW        = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [WORDS];

    // Store write data.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    generate
        if (REG_RESET) begin : g_rst
            // Registered read with a reset output.
            always_ff @(posedge clk) begin
                if (!rst_n)  rdata <= '0;
                else if (re) rdata <= mem[raddr];
            end
        end else begin : g_nrst
            // Registered read without reset.
            always_ff @(posedge clk) begin
                if (re) rdata <= mem[raddr];
            end
        end
    endgenerate

endmodule

// File: rtl/stbuf_rr.sv
// Round-robin three-bank stage buffer between two transform stages.
// The producer fills banks in ring order and the consumer drains them in the
// same order. Every transfer needs a request plus a same-cycle enable.
// Assumes each side walks local addresses so that element ELEMS-1 is its last access to a bank.
module stbuf_rr #(
    parameter int DATA_W    = 20,
    parameter int ELEMS     = 8,
    parameter int NUM_BANKS = 3,
    localparam int LA_W  = $clog2(ELEMS),
    localparam int PA_W  = $clog2(NUM_BANKS * ELEMS),
    localparam int WORDS = NUM_BANKS * ELEMS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [LA_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    input  logic              rd_req,
    input  logic [LA_W-1:0]   rd_addr,
    output logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic            wr_done, rd_done;
    logic [PA_W-1:0] wr_phys, rd_phys;
    logic            rd_valid_q;

    stbuf_occupancy #(.NUM_BANKS(NUM_BANKS)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .wr_last (wr_addr == LA_W'(ELEMS - 1)),
        .rd_req  (rd_req),
        .rd_last (rd_addr == LA_W'(ELEMS - 1)),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_done (wr_done),
        .rd_done (rd_done)
    );

    stbuf_ring_ptr #(.NUM_BANKS(NUM_BANKS), .ELEMS(ELEMS)) u_wptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (wr_done),
        .local_addr (wr_addr),
        .phys_addr  (wr_phys)
    );

    stbuf_ring_ptr #(.NUM_BANKS(NUM_BANKS), .ELEMS(ELEMS)) u_rptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (rd_done),
        .local_addr (rd_addr),
        .phys_addr  (rd_phys)
    );

    stbuf_dpram #(.WIDTH(DATA_W), .WORDS(WORDS), .REG_RESET(1'b1)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_phys),
        .wdata (wr_data),
        .re    (rd_en),
        .raddr (rd_phys),
        .rdata (rd_data)
    );

    // Read data valid follows a granted read by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid_q <= 1'b0;
        else        rd_valid_q <= rd_en;
    end

    assign rd_valid = rd_valid_q;

endmodule

// File: rtl/stbuf_rr_chk.sv
// Port-level protocol checker for stbuf_rr.
// Keeps its own count of full banks from port activity only.
module stbuf_rr_chk #(
    parameter int ELEMS     = 8,
    parameter int NUM_BANKS = 3,
    localparam int LA_W  = $clog2(ELEMS),
    localparam int CNT_W = $clog2(NUM_BANKS + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_req,
    input logic [LA_W-1:0] wr_addr,
    input logic            wr_en,
    input logic            rd_req,
    input logic [LA_W-1:0] rd_addr,
    input logic            rd_en,
    input logic            rd_valid
);
    logic [CNT_W-1:0] seen_full;
    logic             fin_w, fin_r;

    assign fin_w = wr_en && (wr_addr == LA_W'(ELEMS - 1));
    assign fin_r = rd_en && (rd_addr == LA_W'(ELEMS - 1));

    // Independent fill count from completions and releases at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n)             seen_full <= '0;
        else if (fin_w && !fin_r) seen_full <= seen_full + 1'b1;
        else if (fin_r && !fin_w) seen_full <= seen_full - 1'b1;
    end

    a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_req);
    a_r2_grant_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && seen_full != CNT_W'(NUM_BANKS)) |-> wr_en);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_full == CNT_W'(NUM_BANKS)) |-> !wr_en);
    a_r4_no_early_read: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_full == '0) |-> !rd_en);
    a_r5_read_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && seen_full != '0) |-> rd_en);
    a_r5_read_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> rd_req);
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

endmodule

bind stbuf_rr stbuf_rr_chk #(.ELEMS(ELEMS), .NUM_BANKS(NUM_BANKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .wr_addr  (wr_addr),
    .wr_en    (wr_en),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_en    (rd_en),
    .rd_valid (rd_valid)
);

// File: tb/stbuf_rr_test.sv
`timescale 1ns/1ps
// Scoreboard bench: write tasks push expected words, a monitor pops them on rd_valid.
module stbuf_rr_test;
    localparam int DW = 20;
    localparam int EL = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_req = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_en;
    logic          rd_req = 1'b0;
    logic [2:0]    rd_addr = '0;
    logic          rd_en;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int checks = 0;
    int errors = 0;
    int valids = 0;
    bit done = 1'b0;
    logic [DW-1:0] sb [$];

    stbuf_rr uut (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int blk, input int a);
        if (blk == 2 && a == 0) return 20'hFFFFF;   // R9 extreme
        if (blk == 2 && a == 1) return 20'h80000;   // R9 extreme
        return DW'((blk * 40503 + a * 1031) ^ 32'h5A5A5);
    endfunction

    // Write one element and wait for its grant; push the expected word.
    task automatic put(input int blk, input int a, input int stall);
        int tries = 0;
        repeat (stall) @(negedge clk);
        forever begin
            @(negedge clk);
            wr_req = 1'b1; wr_addr = 3'(a); wr_data = pattern(blk, a);
            #1;
            if (wr_en) begin
                sb.push_back(pattern(blk, a));
                @(posedge clk); #1 wr_req = 1'b0;
                break;
            end
            tries++;
            if (tries > 60) begin
                wr_req = 1'b0;
                check(1'b0, "R2/R8 write never granted", 0, 1);
                break;
            end
        end
    endtask

    task automatic put_block(input int blk, input int maxstall);
        for (int a = 0; a < EL; a++) put(blk, a, (maxstall == 0) ? 0 : int'($urandom % maxstall));
    endtask

    // Read one element and wait for its grant.
    task automatic get(input int a, input int stall);
        int tries = 0;
        repeat (stall) @(negedge clk);
        forever begin
            @(negedge clk);
            rd_req = 1'b1; rd_addr = 3'(a);
            #1;
            if (rd_en) begin
                @(posedge clk); #1 rd_req = 1'b0;
                break;
            end
            tries++;
            if (tries > 60) begin
                rd_req = 1'b0;
                check(1'b0, "R5 read never granted", 0, 1);
                break;
            end
        end
    endtask

    task automatic get_block(input int maxstall);
        for (int a = 0; a < EL; a++) get(a, (maxstall == 0) ? 0 : int'($urandom % maxstall));
    endtask

    // Probe grants within one low clock phase without causing a transfer.
    task automatic probe_wr(input bit exp, input string req);
        @(negedge clk);
        wr_req = 1'b1; wr_addr = '0;
        #1 check(wr_en == exp, req, wr_en, exp);
        wr_req = 1'b0;
    endtask

    task automatic probe_rd(input bit exp, input string req);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = '0;
        #1 check(rd_en == exp, req, rd_en, exp);
        rd_req = 1'b0;
    endtask

    // Monitor: compare every valid read against the scoreboard (R6, R7, R9).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            valids++;
            if (sb.size() == 0) begin
                check(1'b0, "R7 duplicate or spurious read", int'(rd_data), 0);
            end else begin
                logic [DW-1:0] e;
                e = sb.pop_front();
                check(rd_data == e, "R6/R7/R9 data order", int'(rd_data), int'(e));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #1500000;
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        @(negedge clk);
        #1 check(wr_en == 1'b0, "R1 wr_en idle", wr_en, 0);
        check(rd_valid == 1'b0, "R1 rd_valid low", rd_valid, 0);
        probe_rd(1'b0, "R1 no read grant when empty");
        probe_wr(1'b1, "R1 write granted after reset");

        // R4: block 0 not readable before its element 7.
        for (int a = 0; a < EL - 1; a++) put(0, a, 0);
        probe_rd(1'b0, "R4 no read before last element");
        put(0, EL - 1, 0);
        probe_rd(1'b1, "R4 read granted after last element");

        // R3: fill all three banks, then a write must stall.
        put_block(1, 0);
        put_block(2, 0);
        probe_wr(1'b0, "R3 write stalls with three full");
        probe_wr(1'b0, "R3 write still stalled");

        // R7: draining one block frees a bank; two-operand fetch is two reads.
        get_block(0);
        probe_wr(1'b1, "R7 release frees a bank");

        // R8: complete block 3 and release block 1 on the same edge.
        fork
            put_block(3, 0);
            get_block(0);
        join
        put_block(4, 0);
        probe_wr(1'b0, "R8 three full after simultaneous events");

        // Drain blocks 2, 3, 4.
        repeat (3) get_block(0);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R7 directed drain complete", sb.size(), 0);
        probe_rd(1'b0, "R5 no read grant when drained");

        // Random stalls on both sides.
        fork
            for (int b = 5; b < 17; b++) put_block(b, 4);
            for (int b = 0; b < 12; b++) get_block(4);
        join
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R7 no loss after random phase", sb.size(), 0);
        check(valids == 17 * EL, "R6 read count", valids, 17 * EL);
        check(rd_valid == 1'b0, "R6 valid low when idle", rd_valid, 0);
        finish_run();
    end

endmodule